// File: doc/BRIEF.md
# Repeating Up-Counter Time Base

This block is a 16-bit up-counting time base. A clock divider turns the system clock into counter ticks. The counter steps from zero up to a reload limit and then wraps back to zero. Each wrap raises an overflow pulse. A repetition down-counter decides which wraps also raise an update event. The update event is the moment at which the buffered settings (divider ratio, and the reload limit when buffering is on) move into the working copies that the counter actually uses.

Software drives the block through a single-cycle write port with four addresses. It can choose whether a new reload limit applies at once or waits for the next update event. It can also mask update events while it rewrites several settings, or force an update event that restarts the count from zero. The block is used as the tick source for periodic work: the overflow pulse marks every period, and the update pulse marks every (N+1)-th period.

Top module: `tmb_timebase`

## Requirements
- R1: While reset is held and on the first cycle after it, `cnt_o` is 0 and `ovf_o` and `upd_o` are 0.
- R2: A write with `wr_en` high stores `wr_data` at the next rising edge. Address 0 is control, with bit 0 run, bit 1 reload buffering, bit 2 update mask and bit 3 force update. Address 1 is the divider value, address 2 is the reload limit (reset value all ones) and address 3 is the repetition value (low 8 bits).
- R3: While run is set, the counter advances once every D+1 clock cycles, where D is the working divider value. While run is clear and no forced update is pending, `cnt_o` holds its value.
- R4: On the tick where the counter is at or above the working reload limit, it wraps to 0. `ovf_o` is then high for one cycle, in the same cycle that `cnt_o` first shows 0.
- R5: With reload buffering off, a newly written reload limit decides the very next wrap.
- R6: With reload buffering on, a newly written reload limit takes effect only after the next update event.
- R7: A newly written divider value takes effect only after the next update event. Until then the old tick rate stays in force.
- R8: With a repetition value N, `upd_o` is raised on every (N+1)-th wrap and on no wrap in between. N = 0 raises it on every wrap.
- R9: Writing control with bit 3 set produces a forced update on the following edge. At that edge the divider phase and the counter clear to 0, the working copies load and the repetition counter reloads. `upd_o` rises one cycle after the write edge.
- R10: While the update mask is set, no `upd_o` pulse appears and no working copy loads, but wraps still raise `ovf_o`. A forced update under the mask still clears the counter, but it produces no pulse.
- R11: The force bit clears itself after one cycle, so one forced write gives exactly one `upd_o` pulse, one cycle wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select (0 control, 1 divider, 2 reload limit, 3 repetition) |
| wr_data | input | 16 | Write data |
| cnt_o | output | 16 | Live counter value |
| ovf_o | output | 1 | One-cycle pulse on each wrap |
| upd_o | output | 1 | One-cycle update-event pulse |

## Verification
The count path is exercised with a divide-by-3 clock and a limit of 4, with a repetition value of 2, and with a divider rewritten in the middle of a period. The exact cycle of each pulse separates immediate from deferred divider ratios, and every third wrap separates correct repetition gating from gating on every wrap. A limit lowered from 9 to 3 is tried once with buffering off and once, from 3 to 7, with buffering on; the wrap times show whether the new limit applied at once or only after an update. A final pass masks updates while the limit changes, then unmasks them. It shows that masked wraps still overflow, that they load nothing, and that a forced restart under the mask raises no pulse.

// File: rtl/tmb_pkg.sv
package tmb_pkg;

    typedef enum logic [1:0] {
        ADDR_CTRL = 2'd0,
        ADDR_DIV  = 2'd1,
        ADDR_TOP  = 2'd2,
        ADDR_REP  = 2'd3
    } tmb_addr_e;

    // Control word, bit 3 down to bit 0
    typedef struct packed {
        logic force_upd;
        logic upd_mask;
        logic top_buf;
        logic run;
    } tmb_ctrl_t;

    localparam int CTRL_W = $bits(tmb_ctrl_t);

    function automatic tmb_ctrl_t decode_ctrl(input logic [CTRL_W-1:0] v);
        return tmb_ctrl_t'(v);
    endfunction

endpackage

// File: rtl/tmb_regs.sv
module tmb_regs
    import tmb_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int REP_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output tmb_ctrl_t         ctrl_o,
    output logic [DATA_W-1:0] div_o,
    output logic [DATA_W-1:0] top_o,
    output logic [REP_W-1:0]  rep_o
);

    tmb_ctrl_t ctrl_q;
    logic [DATA_W-1:0] div_q;
    logic [DATA_W-1:0] top_q;
    logic [REP_W-1:0]  rep_q;
    logic ctrl_wr;

    assign ctrl_wr = wr_en && (tmb_addr_e'(wr_addr) == ADDR_CTRL);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            div_q  <= '0;
            top_q  <= '1;
            rep_q  <= '0;
        end else begin
            ctrl_q.force_upd <= 1'b0;
            if (wr_en) begin
                case (tmb_addr_e'(wr_addr))
                    ADDR_CTRL: ctrl_q <= decode_ctrl(wr_data[CTRL_W-1:0]);
                    ADDR_DIV:  div_q  <= wr_data;
                    ADDR_TOP:  top_q  <= wr_data;
                    ADDR_REP:  rep_q  <= wr_data[REP_W-1:0];
                    default:   ;
                endcase
            end
        end
    end

    assign ctrl_o = ctrl_q;
    assign div_o  = div_q;
    assign top_o  = top_q;
    assign rep_o  = rep_q;

    // R11
    ug_self_clear_chk: assert property (@(posedge clk) disable iff (rst)
        ctrl_q.force_upd && !(ctrl_wr && wr_data[CTRL_W-1]) |=> !ctrl_q.force_upd);

endmodule

// File: rtl/tmb_prescaler.sv
module tmb_prescaler #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run_i,
    input  logic             clear_i,
    input  logic             uev_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             tick_o
);

    logic [DIV_W-1:0] div_sh;
    logic [DIV_W-1:0] phase_q;
    logic             tick;

    assign tick = run_i && (phase_q >= div_sh);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= '0;
            div_sh  <= '0;
        end else begin
            if (clear_i) begin
                phase_q <= '0;
            end else if (run_i) begin
                phase_q <= tick ? '0 : phase_q + 1'b1;
            end
            if (uev_i) begin
                div_sh <= div_i;
            end
        end
    end

    assign tick_o = tick;

    // R7
    psc_shadow_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !uev_i |=> $stable(div_sh));

endmodule

// File: rtl/tmb_counter.sv
module tmb_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_i,
    input  logic             clear_i,
    input  logic             uev_i,
    input  logic             buf_en_i,
    input  logic [CNT_W-1:0] top_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             wrap_o,
    output logic             ovf_o
);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] top_sh;
    logic [CNT_W-1:0] top_act;
    logic             wrap;
    logic             ovf_q;

    assign top_act = buf_en_i ? top_sh : top_i;
    assign wrap    = tick_i && !clear_i && (cnt_q >= top_act);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            top_sh <= '1;
            ovf_q  <= 1'b0;
        end else begin
            ovf_q <= wrap;
            if (clear_i) begin
                cnt_q <= '0;
            end else if (tick_i) begin
                cnt_q <= wrap ? '0 : cnt_q + 1'b1;
            end
            if (uev_i) begin
                top_sh <= top_i;
            end
        end
    end

    assign cnt_o  = cnt_q;
    assign wrap_o = wrap;
    assign ovf_o  = ovf_q;

    // R4
    ovf_wraps_zero_chk: assert property (@(posedge clk) disable iff (rst)
        ovf_q |-> cnt_q == '0);

    // R6
    top_shadow_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !uev_i |=> $stable(top_sh));

endmodule

// File: rtl/tmb_repeat.sv
module tmb_repeat #(
    parameter int REP_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wrap_i,
    input  logic             force_i,
    input  logic             mask_i,
    input  logic [REP_W-1:0] rep_i,
    output logic             uev_o,
    output logic             upd_o
);

    logic [REP_W-1:0] left_q;
    logic             last;
    logic             uev;
    logic             upd_q;

    assign last = (left_q == '0);
    assign uev  = !mask_i && (force_i || (wrap_i && last));

    always_ff @(posedge clk) begin
        if (rst) begin
            left_q <= '0;
            upd_q  <= 1'b0;
        end else begin
            upd_q <= uev;
            if (uev) begin
                left_q <= rep_i;
            end else if (wrap_i && !last) begin
                left_q <= left_q - 1'b1;
            end
        end
    end

    assign uev_o = uev;
    assign upd_o = upd_q;

    // R10
    masked_update_chk: assert property (@(posedge clk) disable iff (rst)
        mask_i |=> !upd_q);

    // R8
    rep_gap_chk: assert property (@(posedge clk) disable iff (rst)
        wrap_i && (left_q != '0) |=> !upd_q);

endmodule

// File: rtl/tmb_timebase.sv
module tmb_timebase
    import tmb_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int REP_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [CNT_W-1:0] wr_data,
    output logic [CNT_W-1:0] cnt_o,
    output logic             ovf_o,
    output logic             upd_o
);

    tmb_ctrl_t        ctrl;
    logic [CNT_W-1:0] div_val;
    logic [CNT_W-1:0] top_val;
    logic [REP_W-1:0] rep_val;
    logic             tick;
    logic             wrap;
    logic             uev;

    tmb_regs #(.DATA_W(CNT_W), .REP_W(REP_W)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .ctrl_o  (ctrl),
        .div_o   (div_val),
        .top_o   (top_val),
        .rep_o   (rep_val)
    );

    tmb_prescaler #(.DIV_W(CNT_W)) u_presc (
        .clk     (clk),
        .rst     (rst),
        .run_i   (ctrl.run),
        .clear_i (ctrl.force_upd),
        .uev_i   (uev),
        .div_i   (div_val),
        .tick_o  (tick)
    );

    tmb_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .tick_i   (tick),
        .clear_i  (ctrl.force_upd),
        .uev_i    (uev),
        .buf_en_i (ctrl.top_buf),
        .top_i    (top_val),
        .cnt_o    (cnt_o),
        .wrap_o   (wrap),
        .ovf_o    (ovf_o)
    );

    tmb_repeat #(.REP_W(REP_W)) u_rep (
        .clk     (clk),
        .rst     (rst),
        .wrap_i  (wrap),
        .force_i (ctrl.force_upd),
        .mask_i  (ctrl.upd_mask),
        .rep_i   (rep_val),
        .uev_o   (uev),
        .upd_o   (upd_o)
    );

    // R3
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !ctrl.run && !ctrl.force_upd |=> $stable(cnt_o));

endmodule

// File: tb/tmb_timebase_bench.sv
`timescale 1ns/1ps
module tmb_timebase_bench;

    localparam logic [15:0] C_RUN = 16'd1, C_BUF = 16'd2, C_MASK = 16'd4, C_FORCE = 16'd8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = 2'd0;
    logic [15:0] wr_data = 16'd0;
    logic [15:0] cnt_o;
    logic        ovf_o, upd_o;

    int unsigned cyc = 0;
    int nchk = 0;
    int nfail = 0;
    bit finished = 0;

    int unsigned q_at[$];
    bit          q_ovf[$];
    bit          q_upd[$];
    string       q_tag[$];

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    tmb_timebase u_tmb_timebase (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .cnt_o(cnt_o), .ovf_o(ovf_o), .upd_o(upd_o)
    );

    // Monitor: pops the expected pulse list as pulses appear
    always @(negedge clk) begin
        if (!rst && (ovf_o || upd_o)) begin
            nchk++;
            if (q_at.size() == 0) begin
                nfail++;
                $display("FAIL unexpected pulse at cycle %0d: actual ovf=%0b upd=%0b expected none",
                         cyc, ovf_o, upd_o);
            end else begin
                int unsigned e_at;
                bit e_ovf, e_upd;
                string e_tag;
                e_at = q_at.pop_front();
                e_ovf = q_ovf.pop_front();
                e_upd = q_upd.pop_front();
                e_tag = q_tag.pop_front();
                if (e_at != cyc || e_ovf != ovf_o || e_upd != upd_o || (ovf_o && cnt_o != 0)) begin
                    nfail++;
                    $display("FAIL %s: actual cycle %0d ovf=%0b upd=%0b cnt=%0d, expected cycle %0d ovf=%0b upd=%0b",
                             e_tag, cyc, ovf_o, upd_o, cnt_o, e_at, e_ovf, e_upd);
                end
            end
        end
    end

    task automatic push(input int unsigned at, input bit o, input bit u, input string tag);
        q_at.push_back(at); q_ovf.push_back(o); q_upd.push_back(u); q_tag.push_back(tag);
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_until(input int unsigned c);
        while (cyc < c) @(negedge clk);
    endtask

    task automatic check_eq(input string tag, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic drain(input string tag);
        repeat (3) @(negedge clk);
        check_eq({tag, " pending pulses"}, q_at.size(), 0);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!finished) begin
            nfail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    initial begin : driver
        int unsigned t0;
        int unsigned te;
        repeat (3) @(negedge clk);
        check_eq("R1 cnt in reset", cnt_o, 0);
        rst = 1'b0;
        @(negedge clk);
        check_eq("R1 cnt", cnt_o, 0);
        check_eq("R1 ovf", ovf_o, 0);
        check_eq("R1 upd", upd_o, 0);

        // Basic count: divide by 3, limit 4, forced load while stopped
        wr(2'd1, 16'd2);
        wr(2'd2, 16'd4);
        wr(2'd3, 16'd0);
        wr(2'd0, C_FORCE);
        t0 = cyc;
        push(t0 + 1, 0, 1, "R9 forced update while stopped");
        wait_until(t0 + 2);
        check_eq("R11 force pulse one cycle", upd_o, 0);
        check_eq("R9 counter cleared", cnt_o, 0);
        wr(2'd0, C_RUN);
        t0 = cyc;
        for (int m = 1; m <= 3; m++) push(t0 + 15 * m, 1, 1, "R4 wrap period");
        wait_until(t0 + 4);
        check_eq("R3 one tick per 3 cycles", cnt_o, 1);
        wait_until(t0 + 7);
        check_eq("R3 two ticks", cnt_o, 2);
        te = t0 + 45;
        wait_until(te + 7);
        check_eq("R2 R3 count after wrap", cnt_o, 2);
        wr(2'd0, 16'd0);
        repeat (20) @(negedge clk);
        check_eq("R3 hold while stopped", cnt_o, 2);
        drain("R3");

        // Repetition value 2
        wr(2'd3, 16'd2);
        wr(2'd0, C_FORCE | C_RUN);
        t0 = cyc;
        push(t0 + 1, 0, 1, "R9 forced restart");
        for (int m = 1; m <= 6; m++) push(t0 + 1 + 15 * m, 1, (m % 3) == 0, "R8 every third wrap");
        wait_until(t0 + 91);
        wr(2'd0, 16'd0);
        drain("R8");

        // Divider rewritten mid-period
        wr(2'd3, 16'd0);
        wr(2'd0, C_FORCE | C_RUN);
        t0 = cyc;
        push(t0 + 1, 0, 1, "R9");
        push(t0 + 16, 1, 1, "R7 old ratio");
        push(t0 + 31, 1, 1, "R7 old ratio kept until update");
        push(t0 + 36, 1, 1, "R7 new ratio");
        push(t0 + 41, 1, 1, "R7 new ratio");
        wait_until(t0 + 20);
        wr(2'd1, 16'd0);
        wait_until(t0 + 41);
        wr(2'd0, 16'd0);
        drain("R7");

        // Limit lowered with buffering off
        wr(2'd2, 16'd9);
        wr(2'd0, C_FORCE | C_RUN);
        t0 = cyc;
        push(t0 + 1, 0, 1, "R9");
        push(t0 + 5, 1, 1, "R5 new limit at once");
        push(t0 + 9, 1, 1, "R5");
        push(t0 + 13, 1, 1, "R5");
        wr(2'd2, 16'd3);
        wait_until(t0 + 13);
        wr(2'd0, 16'd0);
        drain("R5");

        // Limit raised with buffering on
        wr(2'd0, C_FORCE | C_BUF | C_RUN);
        t0 = cyc;
        push(t0 + 1, 0, 1, "R9");
        push(t0 + 5, 1, 1, "R6 old limit until update");
        push(t0 + 13, 1, 1, "R6 buffered limit");
        push(t0 + 21, 1, 1, "R6");
        wr(2'd2, 16'd7);
        wait_until(t0 + 21);
        wr(2'd0, 16'd0);
        drain("R6");

        // Update mask: forced restart and wraps raise no update
        wr(2'd0, C_FORCE | C_MASK | C_BUF | C_RUN);
        t0 = cyc;
        push(t0 + 9, 1, 0, "R10 masked wrap");
        push(t0 + 17, 1, 1, "R10 limit not loaded while masked");
        push(t0 + 20, 1, 1, "R6 limit loaded after unmask");
        push(t0 + 23, 1, 1, "R6");
        wr(2'd2, 16'd2);
        check_eq("R10 masked force clears counter", cnt_o, 0);
        wait_until(t0 + 12);
        wr(2'd0, C_BUF | C_RUN);
        wait_until(t0 + 23);
        wr(2'd0, 16'd0);
        drain("R10");

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

endmodule